// File: doc/BRIEF.md
# Option Byte Loader and Read-Protection Decoder

This block brings a small set of configuration bytes out of a non-volatile array into live registers. Each stored byte sits beside its bitwise complement; after reset, or when software asks for a reload, the loader steps through the pairs one per clock. It checks each pair and fills the user-configuration, user-data and write-protect registers. A pair whose complement does not match is replaced by the erased value 0xFF and raises a sticky error flag. Until every pair has been taken, a not-ready output stays high.

The first pair holds the read-protection byte. The block turns it into a three-level protection code, and from that code it decides whether debug-mode accesses to main flash are allowed. It also screens option-byte program and erase requests against the current level. Two of its decisions have lasting effect: lowering protection from level 1 first asks for a mass erase and a reset of the backup registers, and level 2 can never be left.

Top module: `optl_top`

## Requirements
- R1: After reset is released, notReady stays 1 for seven rising edges and drops to 0 on the eighth; while reset is held, notReady is 1 and rdpLevel is 01.
- R2: Pair k is read at nvAddr = k, with the byte on nvData[7:0] and its complement on nvData[15:8]. Pair 0 is read protection, pair 1 is userCfg, pairs 2 and 3 are userData0 and userData1, and pairs 4 to 7 fill wrProt bytes from [7:0] up to [31:24].
- R3: rdpLevel is 00 when the loaded protection byte is 0xAA (with complement 0x55), 11 when it is 0xCC (with complement 0x33), and 01 for any other byte or pair. The value 10 never appears.
- R4: A pair whose upper byte is not the bitwise inverse of its lower byte is loaded as 0xFF and sets optErr. optErr is cleared when a reload starts.
- R5: A reloadReq while ready gives a one-cycle sysResetReq on the next edge. It restarts the load with notReady high, drops notReady eight edges later, and takes the array's current contents.
- R6: When dbgMode is 1 and rdpLevel is not 00, accRead gives busErr and accProg or accErase gives pgErrSet in the same cycle. At level 00, or with dbgMode 0, neither is raised.
- R7: At level 01, a request to program byte index 0 with 0xAA pulses massEraseReq and bkpResetReq together on the next edge, and optGrant follows one edge later.
- R8: At level 11, a program request to byte index 0 and any option erase request are refused. wrpErrSet pulses on the next edge and optGrant stays 0.
- R9: Any other option program or erase request gets a one-cycle optGrant on the next edge. Requests made while notReady is 1 are ignored: no grant and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| nvAddr | output | 3 | Pair index read from the array |
| nvData | input | 16 | Pair read data: complement in [15:8], byte in [7:0] |
| reloadReq | input | 1 | Software-forced reload of the option bytes |
| notReady | output | 1 | High until all pairs are loaded |
| sysResetReq | output | 1 | One-cycle system reset request on reload |
| rdpLevel | output | 2 | Read-protection level code |
| optErr | output | 1 | Complement mismatch seen during the last load |
| userCfg | output | 8 | User configuration byte |
| userData0 | output | 8 | First user data byte |
| userData1 | output | 8 | Second user data byte |
| wrProt | output | 32 | Write-protect bytes |
| dbgMode | input | 1 | Access comes from debug or boot-from-RAM code |
| accRead | input | 1 | Main flash read attempt |
| accProg | input | 1 | Main flash program attempt |
| accErase | input | 1 | Main flash erase attempt |
| busErr | output | 1 | Refuse the read with a bus error |
| pgErrSet | output | 1 | Set the programming-error flag |
| optProgReq | input | 1 | Option byte program request |
| optByteIdx | input | 3 | Index of the option byte to program |
| optProgData | input | 8 | Value to be programmed |
| optEraseReq | input | 1 | Option area erase request |
| optGrant | output | 1 | Option operation may proceed |
| wrpErrSet | output | 1 | Set the write-protection error flag |
| massEraseReq | output | 1 | Request a mass erase of main flash |
| bkpResetReq | output | 1 | Request a reset of the backup registers |

## Verification
The bench counts the exact edge on which notReady falls after reset and after a reload. A loader that is off by one pair would release it a cycle early or late, or put bytes into the wrong register. It places bad complements on the protection pair and on a user pair. A design that decoded the raw byte would report level 0 from a corrupted 0xAA, and one that forgot to clear the error would still show optErr after a clean reload. It also checks the order of erase request and grant when protection is lowered. It tries to program the protection byte at level 2, where a design that let the request through would make that level reversible.

// File: rtl/optl_pkg.sv
package optl_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_USER  = 4;                 // rdp, cfg, data0, data1
  localparam int NUM_WRP   = 4;
  localparam int NUM_PAIRS = NUM_USER + NUM_WRP;
  localparam int IDX_W     = $clog2(NUM_PAIRS);
  localparam int WRP_W     = NUM_WRP * BYTE_W;

  localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] RDP_OPEN    = 8'hAA;
  localparam logic [BYTE_W-1:0] RDP_LOCKED  = 8'hCC;

  localparam logic [1:0] LVL_0 = 2'b00;
  localparam logic [1:0] LVL_1 = 2'b01;
  localparam logic [1:0] LVL_2 = 2'b11;

  typedef struct packed {
    logic             clr;   // restart: registers to erased, error cleared
    logic             load;  // capture the pair at idx this cycle
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/optl_dp.sv
module optl_dp
  import optl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [2*BYTE_W-1:0] nvData,
  input  logic              dbgMode,
  input  logic              accRead,
  input  logic              accProg,
  input  logic              accErase,
  output logic [1:0]        rdpLevel,
  output logic              optErr,
  output logic [BYTE_W-1:0] userCfg,
  output logic [BYTE_W-1:0] userData0,
  output logic [BYTE_W-1:0] userData1,
  output logic [WRP_W-1:0]  wrProt,
  output logic              busErr,
  output logic              pgErrSet
);
  logic [BYTE_W-1:0] optReg [NUM_PAIRS];
  logic [BYTE_W-1:0] rawByte, rawComp;
  logic              pairBad;

  assign rawByte = nvData[BYTE_W-1:0];
  assign rawComp = nvData[2*BYTE_W-1:BYTE_W];
  assign pairBad = (rawComp != ~rawByte);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PAIRS; i++) optReg[i] <= ERASED_BYTE;
      optErr <= 1'b0;
    end else if (strb.clr) begin
      for (int i = 0; i < NUM_PAIRS; i++) optReg[i] <= ERASED_BYTE;
      optErr <= 1'b0;
    end else if (strb.load) begin
      optReg[strb.idx] <= pairBad ? ERASED_BYTE : rawByte;
      if (pairBad) optErr <= 1'b1;
    end
  end

  // level decode: a mismatched pair already reads as erased, i.e. level 1
  always_comb begin
    unique case (optReg[0])
      RDP_OPEN:   rdpLevel = LVL_0;
      RDP_LOCKED: rdpLevel = LVL_2;
      default:    rdpLevel = LVL_1;
    endcase
  end

  assign userCfg   = optReg[1];
  assign userData0 = optReg[2];
  assign userData1 = optReg[3];

  for (genvar w = 0; w < NUM_WRP; w++) begin : g_wrp
    assign wrProt[w*BYTE_W +: BYTE_W] = optReg[NUM_USER + w];
  end

  logic guarded;
  assign guarded  = dbgMode && (rdpLevel != LVL_0);
  assign busErr   = guarded && accRead;
  assign pgErrSet = guarded && (accProg || accErase);

  p_level_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdpLevel != 2'b10);
  p_bad_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.clr && pairBad) |=> optErr);
  p_bus_err_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busErr || pgErrSet) |-> (rdpLevel != LVL_0));
endmodule

// File: rtl/optl_ctrl.sv
module optl_ctrl
  import optl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reloadReq,
  input  logic [1:0]        rdpLevel,
  input  logic              optProgReq,
  input  logic [IDX_W-1:0]  optByteIdx,
  input  logic [BYTE_W-1:0] optProgData,
  input  logic              optEraseReq,
  output strobe_t           strb,
  output logic              notReady,
  output logic              sysResetReq,
  output logic              optGrant,
  output logic              wrpErrSet,
  output logic              massEraseReq,
  output logic              bkpResetReq
);
  typedef enum logic [1:0] {ST_LOAD, ST_READY, ST_WIPE} state_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAIRS - 1);

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic             rdpTarget;

  assign rdpTarget = (optByteIdx == '0);
  assign notReady  = (state == ST_LOAD);

  assign strb.load = (state == ST_LOAD);
  assign strb.clr  = (state == ST_READY) && reloadReq;
  assign strb.idx  = idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_LOAD;
      idx          <= '0;
      sysResetReq  <= 1'b0;
      optGrant     <= 1'b0;
      wrpErrSet    <= 1'b0;
      massEraseReq <= 1'b0;
      bkpResetReq  <= 1'b0;
    end else begin
      sysResetReq  <= 1'b0;
      optGrant     <= 1'b0;
      wrpErrSet    <= 1'b0;
      massEraseReq <= 1'b0;
      bkpResetReq  <= 1'b0;
      unique case (state)
        ST_LOAD: begin
          if (idx == LAST_IDX) begin
            state <= ST_READY;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_READY: begin
          if (reloadReq) begin
            sysResetReq <= 1'b1;
            state       <= ST_LOAD;
            idx         <= '0;
          end else if (optProgReq) begin
            if (rdpTarget && rdpLevel == LVL_2) begin
              wrpErrSet <= 1'b1;
            end else if (rdpTarget && rdpLevel == LVL_1 && optProgData == RDP_OPEN) begin
              massEraseReq <= 1'b1;
              bkpResetReq  <= 1'b1;
              state        <= ST_WIPE;
            end else begin
              optGrant <= 1'b1;
            end
          end else if (optEraseReq) begin
            if (rdpLevel == LVL_2) wrpErrSet <= 1'b1;
            else                   optGrant  <= 1'b1;
          end
        end
        ST_WIPE: begin
          optGrant <= 1'b1;
          state    <= ST_READY;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  p_reload_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> notReady);
  p_wipe_then_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    massEraseReq |=> optGrant);
  p_wipe_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    massEraseReq |-> bkpResetReq);
  p_refuse_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrpErrSet |-> (!optGrant && !massEraseReq));
  p_grant_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    optGrant |-> !notReady);
endmodule

// File: rtl/optl_top.sv
module optl_top
  import optl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output logic [2:0]  nvAddr,
  input  logic [15:0] nvData,
  input  logic        reloadReq,
  output logic        notReady,
  output logic        sysResetReq,
  output logic [1:0]  rdpLevel,
  output logic        optErr,
  output logic [7:0]  userCfg,
  output logic [7:0]  userData0,
  output logic [7:0]  userData1,
  output logic [31:0] wrProt,
  input  logic        dbgMode,
  input  logic        accRead,
  input  logic        accProg,
  input  logic        accErase,
  output logic        busErr,
  output logic        pgErrSet,
  input  logic        optProgReq,
  input  logic [2:0]  optByteIdx,
  input  logic [7:0]  optProgData,
  input  logic        optEraseReq,
  output logic        optGrant,
  output logic        wrpErrSet,
  output logic        massEraseReq,
  output logic        bkpResetReq
);
  strobe_t strb;

  assign nvAddr = strb.idx;

  optl_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reloadReq(reloadReq), .rdpLevel(rdpLevel),
    .optProgReq(optProgReq), .optByteIdx(optByteIdx), .optProgData(optProgData),
    .optEraseReq(optEraseReq), .strb(strb), .notReady(notReady),
    .sysResetReq(sysResetReq), .optGrant(optGrant), .wrpErrSet(wrpErrSet),
    .massEraseReq(massEraseReq), .bkpResetReq(bkpResetReq)
  );

  optl_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .nvData(nvData), .dbgMode(dbgMode),
    .accRead(accRead), .accProg(accProg), .accErase(accErase),
    .rdpLevel(rdpLevel), .optErr(optErr), .userCfg(userCfg),
    .userData0(userData0), .userData1(userData1), .wrProt(wrProt),
    .busErr(busErr), .pgErrSet(pgErrSet)
  );
endmodule

// File: tb/test_optl_top.sv
module test_optl_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] nvAddr;
  logic [15:0] nvData;
  logic reloadReq = 0, notReady, sysResetReq, optErr;
  logic [1:0] rdpLevel;
  logic [7:0] userCfg, userData0, userData1;
  logic [31:0] wrProt;
  logic dbgMode = 0, accRead = 0, accProg = 0, accErase = 0, busErr, pgErrSet;
  logic optProgReq = 0, optEraseReq = 0;
  logic [2:0] optByteIdx = 0;
  logic [7:0] optProgData = 0;
  logic optGrant, wrpErrSet, massEraseReq, bkpResetReq;

  logic [15:0] nvMem [8];
  int errors = 0, checks = 0;

  always #10 clk = ~clk;
  assign nvData = nvMem[nvAddr];

  optl_top i_optl_top (.*);

  function automatic logic [15:0] good(input logic [7:0] b);
    return {~b, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic fillGood(input logic [7:0] rdp);
    nvMem[0] = good(rdp);   nvMem[1] = good(8'h5A);
    nvMem[2] = good(8'h12); nvMem[3] = good(8'h34);
    nvMem[4] = good(8'h01); nvMem[5] = good(8'h02);
    nvMem[6] = good(8'h03); nvMem[7] = good(8'h04);
  endtask

  task automatic tReset;
    fillGood(8'hAA);
    rstN = 1'b0;
    cyc(2);
    check("R1 notReady in reset", notReady, 1);
    check("R1 level in reset", rdpLevel, 2'b01);
    rstN = 1'b1;
    cyc(7);
    check("R1 notReady after 7 edges", notReady, 1);
    cyc(1);
    check("R1 notReady after 8 edges", notReady, 0);
  endtask

  task automatic tValues;
    check("R2 userCfg", userCfg, 8'h5A);
    check("R2 userData0", userData0, 8'h12);
    check("R2 userData1", userData1, 8'h34);
    check("R2 wrProt", wrProt, 32'h04030201);
    check("R3 level 0", rdpLevel, 2'b00);
    check("R4 no error", optErr, 0);
  endtask

  task automatic tReload(input string req);
    reloadReq = 1'b1;
    cyc(1);
    reloadReq = 1'b0;
    check({req, " sysResetReq pulse"}, sysResetReq, 1);
    check({req, " notReady on reload"}, notReady, 1);
    cyc(1);
    check({req, " sysResetReq one cycle"}, sysResetReq, 0);
    cyc(6);
    check({req, " still loading"}, notReady, 1);
    cyc(1);
    check({req, " ready after reload"}, notReady, 0);
  endtask

  task automatic tMismatch;
    fillGood(8'hAA);
    nvMem[0] = 16'h00AA;        // bad complement on protection byte
    nvMem[1] = 16'h1234;        // bad complement on user cfg
    tReload("R5");
    check("R4 rdp bad pair gives level 1", rdpLevel, 2'b01);
    check("R4 cfg replaced by FF", userCfg, 8'hFF);
    check("R4 optErr set", optErr, 1);
    check("R2 data kept", userData1, 8'h34);
    fillGood(8'hCC);
    tReload("R5");
    check("R4 optErr cleared by reload", optErr, 0);
    check("R3 level 2", rdpLevel, 2'b11);
  endtask

  task automatic tDebug(input logic [1:0] lvl);
    logic expErr;
    expErr = (lvl != 2'b00);
    dbgMode = 1; accRead = 1; #1;
    check("R6 debug read", busErr, expErr);
    check("R6 read no pgErr", pgErrSet, 0);
    accRead = 0; accProg = 1; #1;
    check("R6 debug prog", pgErrSet, expErr);
    accProg = 0; accErase = 1; #1;
    check("R6 debug erase", pgErrSet, expErr);
    dbgMode = 0; accRead = 1; #1;
    check("R6 user read allowed", busErr, 0);
    check("R6 user erase allowed", pgErrSet, 0);
    accRead = 0; accErase = 0;
    cyc(1);
  endtask

  task automatic optOp(input logic prog, input logic [2:0] idx, input logic [7:0] d);
    optProgReq = prog; optEraseReq = !prog; optByteIdx = idx; optProgData = d;
    cyc(1);
    optProgReq = 0; optEraseReq = 0;
  endtask

  task automatic tLevel2;
    optOp(1, 3'd0, 8'hAA);
    check("R8 rdp prog refused err", wrpErrSet, 1);
    check("R8 rdp prog no grant", optGrant, 0);
    check("R8 no wipe", massEraseReq, 0);
    cyc(1);
    check("R8 err one cycle", wrpErrSet, 0);
    optOp(0, 3'd0, 8'h00);
    check("R8 erase refused", wrpErrSet, 1);
    check("R8 erase no grant", optGrant, 0);
    cyc(1);
    optOp(1, 3'd5, 8'h77);
    check("R9 other byte granted at level 2", optGrant, 1);
    check("R9 no err", wrpErrSet, 0);
    cyc(1);
  endtask

  task automatic tLevel1;
    fillGood(8'h3C);
    tReload("R5");
    check("R3 other byte gives level 1", rdpLevel, 2'b01);
    tDebug(2'b01);
    optOp(1, 3'd0, 8'hAA);
    check("R7 mass erase requested", massEraseReq, 1);
    check("R7 backup reset requested", bkpResetReq, 1);
    check("R7 no grant yet", optGrant, 0);
    cyc(1);
    check("R7 grant after wipe", optGrant, 1);
    check("R7 wipe one cycle", massEraseReq, 0);
    cyc(1);
    check("R7 grant one cycle", optGrant, 0);
    optOp(1, 3'd0, 8'h55);
    check("R9 rdp to non-AA granted", optGrant, 1);
    check("R9 no wipe for non-AA", massEraseReq, 0);
    cyc(1);
    optOp(0, 3'd0, 8'h00);
    check("R9 erase granted at level 1", optGrant, 1);
    cyc(1);
  endtask

  task automatic tIgnoredWhileLoading;
    reloadReq = 1; cyc(1); reloadReq = 0;
    optOp(0, 3'd0, 8'h00);
    check("R9 ignored while loading", optGrant, 0);
    check("R9 no error while loading", wrpErrSet, 0);
    cyc(1);
    check("R9 still no grant", optGrant, 0);
    cyc(8);
    check("R9 ready again", notReady, 0);
    check("R9 nothing pending", optGrant, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tValues();
    tDebug(2'b00);
    optOp(1, 3'd0, 8'hAA);
    check("R9 level 0 rdp prog granted", optGrant, 1);
    check("R9 level 0 no wipe", massEraseReq, 0);
    cyc(1);
    tLevel1();
    tMismatch();
    tDebug(2'b11);
    tLevel2();
    tIgnoredWhileLoading();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule